// File: doc/BRIEF.md
# AXI4 Burst Read Requester

This block sits between a simple request/response client and an AXI4 read port. The client first loads a base address through a one-cycle control strobe. It then presents read requests, each made of a byte offset from that base and a byte count. For every request the block works out the bus address and cuts the read into INCR bursts. No burst passes a 4 KiB page edge or exceeds the configured beat limit. The block issues these bursts on the address channel.

Returning data beats are passed straight through to the client as response packets, one packet per beat. Each packet is trimmed so that only bytes belonging to the request remain, shifted down into the low byte lanes. A packet carries the number of valid bytes, a last marker on the final packet of the request, and an error flag. The error flag stays set from the first beat that came back with a slave or decode error. A request for zero bytes produces one empty last packet and no bus traffic. Only one request is in flight at a time.

Top module: `axi_rd_requester`

## Requirements
- R1: The bus address of a request is the registered base plus the request offset. The first burst starts at that address rounded down to a multiple of the bus width in bytes, and later bursts continue contiguously. A base strobe in the same cycle as a request acceptance applies only to later requests.
- R2: Every issued burst uses burst type INCR (2'b01), a size field equal to log2 of the bus width in bytes, and a bus-width-aligned address.
- R3: No burst reaches past the end of the 4 KiB page (PAGE bytes) in which it starts.
- R4: No burst is longer than MAX_BURST beats (length field = beats - 1). The bursts of one request together cover exactly the beats spanning the requested bytes, with no extra beat.
- R5: In each packet the bytes before the start address and after the end address are dropped. The kept bytes sit in lane 0 upwards in address order, and the unused lanes read zero.
- R6: Each packet reports its count of kept bytes. The last flag is set only on the packet that carries the final requested byte.
- R7: A packet's error flag is set when the current beat or any earlier beat of the same request returned a response code with bit 1 set (2'b10 or 2'b11). The remaining beats are still consumed and forwarded, and the flag clears for the next request.
- R8: req_ready is low from the cycle after a request is accepted until the cycle after its last packet is taken.
- R9: A zero-length request yields exactly one packet with last set, zero count, zero data and no error, and issues no burst.
- R10: After reset, ar_valid and rsp_valid are low and req_ready is high.
- R11: Once ar_valid is raised, ar_valid, ar_addr and ar_len hold steady until ar_ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_valid | input | 1 | Strobe loading a new base address |
| base_addr | input | ADDR_W | Base address value |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_offset | input | ADDR_W | Byte offset from the base |
| req_len | input | LEN_W | Number of bytes to read |
| ar_valid | output | 1 | Read address valid |
| ar_ready | input | 1 | Read address accepted |
| ar_addr | output | ADDR_W | Burst start address |
| ar_len | output | 8 | Burst beats minus one |
| ar_size | output | 3 | log2 of bytes per beat |
| ar_burst | output | 2 | Burst type, always INCR |
| r_valid | input | 1 | Read data beat valid |
| r_ready | output | 1 | Read data beat accepted |
| r_data | input | DATA_W | Read data beat |
| r_resp | input | 2 | Read response code |
| rsp_valid | output | 1 | Response packet valid |
| rsp_ready | input | 1 | Response packet taken |
| rsp_data | output | DATA_W | Kept bytes, packed from lane 0 |
| rsp_len | output | CNT_W | Number of kept bytes |
| rsp_last | output | 1 | Final packet of the request |
| rsp_err | output | 1 | Error seen so far in this request |

## Verification
The hardest case to reach is a request that ends exactly on a page edge, or one that crosses an edge while also needing a split at the beat limit. It is harder still when an error beat lands mid-request and the remaining beats must still flow out under back-pressure. The bench builds these from its ports by choosing base and offset pairs just below 4 KiB edges and next to two address windows that the memory model answers with slave and decode errors. The beat limit is lowered to four so that splitting happens on short requests. Directed cases are followed by a long run of random offsets and lengths. Address-ready, data-valid and response-ready are all throttled at random, so that bursts stall and packets wait.

// File: rtl/axrq_pkg.sv
package axrq_pkg;

  localparam logic [1:0] BURST_INCR = 2'b01;

  // Slave error and decode error both have bit 1 set.
  function automatic logic resp_is_err(logic [1:0] code);
    return code[1];
  endfunction

  // Beats in the next burst: bounded by what is left, by the beat limit,
  // and by the room up to the end of the current page.
  function automatic logic [63:0] next_burst(logic [63:0] addr, logic [63:0] left,
                                             logic [63:0] max_b, logic [63:0] page,
                                             logic [63:0] nb);
    logic [63:0] room;
    logic [63:0] b;
    room = (page - (addr % page)) / nb;
    b = left;
    if (b > max_b) b = max_b;
    if (b > room) b = room;
    return b;
  endfunction

  // Beats that cover a span of bytes measured from an aligned address.
  function automatic logic [63:0] span_beats(logic [63:0] span, logic [63:0] nb);
    return (span + nb - 64'd1) / nb;
  endfunction

endpackage

// File: rtl/axrq_ar_gen.sv
module axrq_ar_gen #(
  parameter int ADDR_W    = 32,
  parameter int BEAT_W    = 33,
  parameter int NB        = 8,
  parameter int MAX_BURST = 256,
  parameter int PAGE      = 4096,
  localparam int LANE_W   = $clog2(NB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [BEAT_W-1:0] ld_beats,
  output logic              ar_valid,
  input  logic              ar_ready,
  output logic [ADDR_W-1:0] ar_addr,
  output logic [7:0]        ar_len
);
  import axrq_pkg::*;

  logic [ADDR_W-1:0] addr_q;
  logic [BEAT_W-1:0] left_q;
  logic [BEAT_W-1:0] burst;
  logic              fire;

  assign burst    = BEAT_W'(next_burst(64'(addr_q), 64'(left_q), 64'(MAX_BURST),
                                       64'(PAGE), 64'(NB)));
  assign ar_valid = (left_q != '0);
  assign ar_addr  = addr_q;
  assign ar_len   = 8'(burst - BEAT_W'(1));
  assign fire     = ar_valid && ar_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      left_q <= '0;
    end else if (ld) begin
      addr_q <= ld_addr;
      left_q <= ld_beats;
    end else if (fire) begin
      addr_q <= addr_q + (ADDR_W'(burst) << LANE_W);
      left_q <= left_q - burst;
    end
  end

endmodule

// File: rtl/axrq_beat_trim.sv
module axrq_beat_trim #(
  parameter int DATA_W  = 64,
  localparam int NB     = DATA_W / 8,
  localparam int LANE_W = $clog2(NB),
  localparam int CNT_W  = LANE_W + 1
) (
  input  logic [DATA_W-1:0] in_data,
  input  logic              first,
  input  logic              last,
  input  logic [LANE_W-1:0] lead,
  input  logic [CNT_W-1:0]  tail,
  output logic [DATA_W-1:0] out_data,
  output logic [CNT_W-1:0]  out_cnt
);
  logic [CNT_W-1:0]  lo;
  logic [CNT_W-1:0]  hi;
  logic [DATA_W-1:0] shifted;

  assign lo      = first ? {1'b0, lead} : '0;
  assign hi      = last ? tail : CNT_W'(NB);
  assign out_cnt = hi - lo;
  assign shifted = in_data >> {lo, 3'b000};

  for (genvar k = 0; k < NB; k++) begin : g_lane
    assign out_data[8*k +: 8] = (CNT_W'(k) < out_cnt) ? shifted[8*k +: 8] : 8'h00;
  end

endmodule

// File: rtl/axi_rd_requester.sv
module axi_rd_requester #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 64,
  parameter int LEN_W     = 32,
  parameter int MAX_BURST = 256,
  parameter int PAGE      = 4096,
  localparam int NB       = DATA_W / 8,
  localparam int LANE_W   = $clog2(NB),
  localparam int CNT_W    = LANE_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_valid,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_offset,
  input  logic [LEN_W-1:0]  req_len,
  output logic              ar_valid,
  input  logic              ar_ready,
  output logic [ADDR_W-1:0] ar_addr,
  output logic [7:0]        ar_len,
  output logic [2:0]        ar_size,
  output logic [1:0]        ar_burst,
  input  logic              r_valid,
  output logic              r_ready,
  input  logic [DATA_W-1:0] r_data,
  input  logic [1:0]        r_resp,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic [CNT_W-1:0]  rsp_len,
  output logic              rsp_last,
  output logic              rsp_err
);
  import axrq_pkg::*;

  localparam int SPAN_W = LEN_W + 2;
  localparam int BEAT_W = LEN_W + 1;

  // Request state
  logic [ADDR_W-1:0] base_q;
  logic              busy_q;
  logic              zlen_q;
  logic              first_q;
  logic              err_q;
  logic [BEAT_W-1:0] left_q;
  logic [LANE_W-1:0] lead_q;
  logic [CNT_W-1:0]  tail_q;

  // Named events
  logic              acc;
  logic              ld;
  logic              beat_fire;
  logic              done;
  logic              last_beat;

  // Request arithmetic
  logic [ADDR_W-1:0] start_addr;
  logic [ADDR_W-1:0] aligned_addr;
  logic [LANE_W-1:0] lead_n;
  logic [SPAN_W-1:0] span_n;
  logic [BEAT_W-1:0] beats_n;
  logic [CNT_W-1:0]  tail_n;

  logic [DATA_W-1:0] trim_data;
  logic [CNT_W-1:0]  trim_cnt;

  assign req_ready    = !busy_q;
  assign acc          = req_valid && req_ready;
  assign ld           = acc && (req_len != '0);
  assign start_addr   = base_q + req_offset;
  assign lead_n       = start_addr[LANE_W-1:0];
  assign aligned_addr = {start_addr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
  assign span_n       = SPAN_W'(lead_n) + SPAN_W'(req_len);
  assign beats_n      = BEAT_W'(span_beats(64'(span_n), 64'(NB)));
  assign tail_n       = (span_n[LANE_W-1:0] == '0) ? CNT_W'(NB)
                                                   : {1'b0, span_n[LANE_W-1:0]};

  assign ar_size  = 3'(LANE_W);
  assign ar_burst = BURST_INCR;

  axrq_ar_gen #(
    .ADDR_W(ADDR_W), .BEAT_W(BEAT_W), .NB(NB),
    .MAX_BURST(MAX_BURST), .PAGE(PAGE)
  ) ar_gen_i (
    .clk(clk), .rst_n(rst_n),
    .ld(ld), .ld_addr(aligned_addr), .ld_beats(beats_n),
    .ar_valid(ar_valid), .ar_ready(ar_ready),
    .ar_addr(ar_addr), .ar_len(ar_len)
  );

  assign last_beat = (left_q == BEAT_W'(1));

  axrq_beat_trim #(.DATA_W(DATA_W)) trim_i (
    .in_data(r_data), .first(first_q), .last(last_beat),
    .lead(lead_q), .tail(tail_q),
    .out_data(trim_data), .out_cnt(trim_cnt)
  );

  // Data beats go straight through to the response side.
  assign r_ready   = busy_q && !zlen_q && rsp_ready;
  assign beat_fire = r_valid && r_ready;
  assign rsp_valid = zlen_q || (busy_q && r_valid);
  assign rsp_last  = zlen_q || last_beat;
  assign rsp_data  = zlen_q ? '0 : trim_data;
  assign rsp_len   = zlen_q ? '0 : trim_cnt;
  assign rsp_err   = !zlen_q && (err_q || resp_is_err(r_resp));
  assign done      = rsp_valid && rsp_ready && rsp_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (base_valid) begin
      base_q <= base_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      zlen_q  <= 1'b0;
      first_q <= 1'b0;
      err_q   <= 1'b0;
      left_q  <= '0;
      lead_q  <= '0;
      tail_q  <= '0;
    end else if (acc) begin
      busy_q  <= 1'b1;
      zlen_q  <= (req_len == '0);
      first_q <= 1'b1;
      err_q   <= 1'b0;
      left_q  <= (req_len == '0) ? '0 : beats_n;
      lead_q  <= lead_n;
      tail_q  <= tail_n;
    end else begin
      if (beat_fire) begin
        left_q  <= left_q - BEAT_W'(1);
        first_q <= 1'b0;
        err_q   <= err_q || resp_is_err(r_resp);
      end
      if (done) begin
        busy_q <= 1'b0;
        zlen_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/axrq_checker.sv
module axrq_checker #(
  parameter int ADDR_W    = 32,
  parameter int NB        = 8,
  parameter int CNT_W     = 4,
  parameter int MAX_BURST = 256,
  parameter int PAGE      = 4096
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ar_valid,
  input logic              ar_ready,
  input logic [ADDR_W-1:0] ar_addr,
  input logic [7:0]        ar_len,
  input logic [2:0]        ar_size,
  input logic [1:0]        ar_burst,
  input logic              req_ready,
  input logic              acc,
  input logic              done,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [CNT_W-1:0]  rsp_len,
  input logic              rsp_last,
  input logic              rsp_err
);
  localparam int LANE_W = $clog2(NB);

  a_r2_ar_fields: assert property (@(posedge clk) disable iff (!rst_n)
    ar_valid |-> (ar_burst == 2'b01) && (ar_size == 3'(LANE_W)) &&
                 ((64'(ar_addr) % 64'(NB)) == 64'd0));

  a_r3_no_page_cross: assert property (@(posedge clk) disable iff (!rst_n)
    ar_valid |-> ((64'(ar_addr) % 64'(PAGE)) + (64'(ar_len) + 64'd1) * 64'(NB))
                 <= 64'(PAGE));

  a_r4_burst_limit: assert property (@(posedge clk) disable iff (!rst_n)
    ar_valid |-> (32'(ar_len) < MAX_BURST));

  a_r11_ar_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_valid && !ar_ready) |=> (ar_valid && $stable(ar_addr) && $stable(ar_len)));

  a_r8_block_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !req_ready);

  a_r8_free_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready);

  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (32'(rsp_len) <= NB));

  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready && rsp_err && !rsp_last) |=> (!rsp_valid || rsp_err));

endmodule

bind axi_rd_requester axrq_checker #(
  .ADDR_W(ADDR_W), .NB(NB), .CNT_W(CNT_W), .MAX_BURST(MAX_BURST), .PAGE(PAGE)
) chk_i (
  .clk(clk), .rst_n(rst_n),
  .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr), .ar_len(ar_len),
  .ar_size(ar_size), .ar_burst(ar_burst),
  .req_ready(req_ready), .acc(acc), .done(done),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_len(rsp_len),
  .rsp_last(rsp_last), .rsp_err(rsp_err)
);

// File: tb/axi_rd_requester_tb.sv
module axi_rd_requester_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int LW = 16;
  localparam int MAXB = 4;
  localparam int PG = 4096;
  localparam int NBY = DW / 8;
  localparam int CW = $clog2(NBY) + 1;
  localparam int LIMIT = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic base_valid = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [AW-1:0] req_offset = '0;
  logic [LW-1:0] req_len = '0;
  logic ar_valid, ar_ready = 1'b0;
  logic [AW-1:0] ar_addr;
  logic [7:0] ar_len;
  logic [2:0] ar_size;
  logic [1:0] ar_burst;
  logic r_valid = 1'b0, r_ready;
  logic [DW-1:0] r_data = '0;
  logic [1:0] r_resp = '0;
  logic rsp_valid, rsp_ready = 1'b0;
  logic [DW-1:0] rsp_data;
  logic [CW-1:0] rsp_len;
  logic rsp_last, rsp_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  axi_rd_requester #(
    .ADDR_W(AW), .DATA_W(DW), .LEN_W(LW), .MAX_BURST(MAXB), .PAGE(PG)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .base_valid(base_valid), .base_addr(base_addr),
    .req_valid(req_valid), .req_ready(req_ready), .req_offset(req_offset),
    .req_len(req_len), .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr),
    .ar_len(ar_len), .ar_size(ar_size), .ar_burst(ar_burst), .r_valid(r_valid),
    .r_ready(r_ready), .r_data(r_data), .r_resp(r_resp), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_len(rsp_len),
    .rsp_last(rsp_last), .rsp_err(rsp_err)
  );

  typedef struct { bit set_base; logic [AW-1:0] v; logic [AW-1:0] off; int len; } op_t;
  typedef struct { logic [DW-1:0] d; int cnt; bit last; bit err; bit zero; } pkt_t;
  typedef struct { logic [DW-1:0] d; logic [1:0] resp; } beat_t;

  op_t ops[$];
  pkt_t expq[$];
  logic [AW-1:0] beatq[$];
  beat_t memq[$];

  int tests = 0, fails = 0, cyc = 0;
  logic [AW-1:0] base_m = '0;
  bit busy_m = 0, acc_seen = 0, stall_prev = 0;
  logic [AW-1:0] prev_addr = '0;
  logic [7:0] prev_len = '0;

  function automatic logic [7:0] mbyte(logic [AW-1:0] a);
    return 8'(a ^ (a >> 8) ^ (a >> 13) ^ 32'h5A);
  endfunction

  function automatic logic [1:0] berr(logic [AW-1:0] a);
    if (a >= 32'h8000 && a < 32'h8100) return 2'b10;
    if (a >= 32'h9000 && a < 32'h9040) return 2'b11;
    return 2'b00;
  endfunction

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic add_base(logic [AW-1:0] v);
    op_t o; o.set_base = 1; o.v = v; o.off = '0; o.len = 0; ops.push_back(o);
  endtask

  task automatic add_req(logic [AW-1:0] off, int len);
    op_t o; o.set_base = 0; o.v = '0; o.off = off; o.len = len; ops.push_back(o);
  endtask

  // Behavioural reference: every byte of the request, grouped by aligned beat.
  task automatic model_accept(logic [AW-1:0] off, int len);
    longint s, e, a0, ba;
    int n;
    bit sticky;
    pkt_t p;
    s = longint'(base_m) + longint'(off);
    e = s + len;
    if (len == 0) begin
      p.d = '0; p.cnt = 0; p.last = 1; p.err = 0; p.zero = 1;
      expq.push_back(p);
      return;
    end
    a0 = s - (s % NBY);
    n = int'((e - a0 + NBY - 1) / NBY);
    sticky = 0;
    for (int k = 0; k < n; k++) begin
      ba = a0 + k * NBY;
      beatq.push_back(AW'(ba));
      sticky = sticky | berr(AW'(ba))[1];
      p.d = '0; p.cnt = 0; p.zero = 0;
      for (int j = 0; j < NBY; j++) begin
        if (ba + j >= s && ba + j < e) begin
          p.d[8*p.cnt +: 8] = mbyte(AW'(ba + j));
          p.cnt++;
        end
      end
      p.last = (k == n - 1);
      p.err = sticky;
      expq.push_back(p);
    end
  endtask

  task automatic on_ar();
    longint room;
    check(ar_burst == 2'b01 && ar_size == 3'd2 && ar_addr[1:0] == 2'b00, "R2",
          "burst/size/align", {ar_burst, ar_size, ar_addr[1:0]}, {2'b01, 3'd2, 2'b00});
    room = (PG - (longint'(ar_addr) % PG)) / NBY;
    check(longint'(ar_len) + 1 <= room, "R3", "page crossing beats",
          longint'(ar_len) + 1, room);
    check(int'(ar_len) < MAXB, "R4", "burst length field", ar_len, MAXB - 1);
    for (int k = 0; k <= int'(ar_len); k++) begin
      beat_t b;
      logic [AW-1:0] a;
      a = ar_addr + AW'(k * NBY);
      if (beatq.size() == 0) begin
        check(0, "R9", "burst beyond request (or for zero length)", a, 0);
      end else begin
        check(a == beatq[0], "R1", "burst beat address", a, beatq[0]);
        void'(beatq.pop_front());
      end
      for (int j = 0; j < NBY; j++) b.d[8*j +: 8] = mbyte(a + AW'(j));
      b.resp = berr(a);
      memq.push_back(b);
    end
  endtask

  task automatic on_rsp();
    pkt_t p;
    if (expq.size() == 0) begin
      check(0, "R6", "unexpected packet", rsp_len, 0);
      return;
    end
    p = expq.pop_front();
    if (p.zero) begin
      check(rsp_len == 0 && rsp_last && !rsp_err && rsp_data == '0, "R9",
            "zero-length packet", {rsp_len, rsp_last, rsp_err}, {3'd0, 2'b10});
    end else begin
      check(rsp_data == p.d, "R5", "trimmed data", rsp_data, p.d);
      check(int'(rsp_len) == p.cnt && rsp_last == p.last, "R6", "count/last",
            {rsp_len, rsp_last}, {3'(p.cnt), p.last});
      check(rsp_err == p.err, "R7", "error flag", rsp_err, p.err);
    end
    if (p.last) busy_m = 0;
  endtask

  initial begin : driver
    forever begin
      @(negedge clk);
      cyc++;
      base_valid = 1'b0;
      if (acc_seen) begin
        req_valid = 1'b0;
        void'(ops.pop_front());
        acc_seen = 0;
      end
      if (rst_n && !req_valid && ops.size() > 0) begin
        if (ops[0].set_base) begin
          base_valid = 1'b1;
          base_addr = ops[0].v;
          void'(ops.pop_front());
        end else if (!busy_m) begin
          req_valid = 1'b1;
          req_offset = ops[0].off;
          req_len = LW'(ops[0].len);
        end
      end
      ar_ready = ($urandom % 4) != 0;
      rsp_ready = ($urandom % 4) != 0;
      r_valid = (memq.size() > 0) && (($urandom % 3) != 0);
      if (memq.size() > 0) begin
        r_data = memq[0].d;
        r_resp = memq[0].resp;
      end
      #1;
      if (rst_n) begin
        if (stall_prev)
          check(ar_valid && ar_addr == prev_addr && ar_len == prev_len, "R11",
                "address held under stall", ar_addr, prev_addr);
        stall_prev = ar_valid && !ar_ready;
        prev_addr = ar_addr;
        prev_len = ar_len;
        if (busy_m) check(!req_ready, "R8", "ready while busy", req_ready, 0);
        if (ar_valid && ar_ready) on_ar();
        if (r_valid && r_ready) void'(memq.pop_front());
        if (rsp_valid && rsp_ready) on_rsp();
        if (req_valid && req_ready) begin
          model_accept(req_offset, int'(req_len));
          busy_m = 1;
          acc_seen = 1;
        end
        if (base_valid) base_m = base_addr;
      end
    end
  end

  initial begin : main
    repeat (4) @(negedge clk);
    check(!ar_valid && !rsp_valid && req_ready, "R10", "reset state",
          {ar_valid, rsp_valid, req_ready}, 3'b001);
    // Directed cases
    add_base(32'h1000);
    add_req(0, 8);          // aligned
    add_req(1, 2);          // inside one beat
    add_req(3, 6);          // unaligned across beats
    add_req(2, 40);         // split by the beat limit
    add_req(5, 0);          // zero length
    add_base(32'h0F00);
    add_req(32'hF6, 30);    // crosses a page edge
    add_req(32'hF0, 16);    // ends exactly at a page edge
    add_base(32'h7FF8);
    add_req(0, 24);         // slave error in the middle
    add_req(32'h110, 9);    // clean request after an error
    add_base(32'h9030);
    add_req(2, 30);         // decode error at the start
    add_req(0, 0);
    for (int i = 0; i < 80; i++) begin
      if (i % 8 == 0) add_base(($urandom % 32'h20000) & 32'hFFFF_FFF0 | (i % 3));
      add_req($urandom % 32'h3000, int'($urandom % 71));
    end
    rst_n = 1'b1;
    while ((ops.size() > 0 || busy_m || req_valid || expq.size() > 0) && cyc < LIMIT)
      @(negedge clk);
    repeat (10) @(negedge clk);
    if (cyc >= LIMIT) check(0, "R6", "watchdog expired", cyc, LIMIT);
    check(beatq.size() == 0, "R4", "beats requested vs spanned", beatq.size(), 0);
    check(memq.size() == 0 && !rsp_valid, "R7", "all beats consumed", memq.size(), 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule